// File: doc/BRIEF.md
# RDS Group Buffer with Interrupts

This block sits behind an RDS synchronizer and block decoder. Each decoded block arrives with four pieces of information: a 16-bit information word, its place in the group (A, B, C or D), a 2-bit error-quality category and a level that shows whether the decoder is in sync. The block stores the word and its tags in a FIFO sized in whole four-block groups. A host reads the oldest entry, the fill level and the sync state through a small register port.

One interrupt line combines seven sticky event sources, and each source has its own enable. The events are:
- sync gained,
- a block D stored,
- the fill level reaching a programmable threshold,
- block A or block B received,
- the content of block A or block B changing from its last correctable value.

With the threshold at one block the host hears about every block. With a high threshold many groups build up before the line rises.

Top module: `rds_group_buffer`

Register addresses on `hostAddr`: 0 STATUS, 1 ENABLE, 2 THRESH, 3 LEVEL, 4 DATA, 5 TAG. Other addresses read as zero.

## Requirements
- R1: After reset the following values hold: STATUS reads 0, ENABLE reads 0x0003, THRESH reads 4, the LEVEL count is 0, the overflow bit is 0 and `irq` is low.
- R2: Stored blocks leave in arrival order. TAG reads {11'b0, empty, err[1:0], pos[1:0]}, where pos is 0=A, 1=B, 2=C, 3=D and err is 00 none, 01 one to two bits, 10 three to five bits, 11 uncorrectable. DATA reads the head word. A host read of DATA with `hostRdEn` high pops the head at the clock edge.
- R3: The FIFO holds 100 blocks (25 groups of 4). A block that arrives while 100 blocks are stored is dropped, the stored contents stay unchanged, and LEVEL bit 14 (overflow) is set. Any write to LEVEL clears the overflow bit, and a drop in the same cycle as that write wins.
- R4: LEVEL bits [6:0] give the number of stored blocks. LEVEL bit 15 shows the sync input as registered one clock earlier.
- R5: STATUS bit 0 sets on the clock edge where the sync input is high and was low at the previous edge.
- R6: STATUS bit 1 sets when a block D is stored.
- R7: STATUS bit 2 sets when a block is stored and the resulting count is greater than or equal to THRESH. A THRESH of 0 fires on every stored block.
- R8: STATUS bits 3 and 4 set on the arrival of any A or B block, whatever its error category and whether or not it is stored.
- R9: STATUS bit 5 (for A) and bit 6 (for B) set when a correctable word differs from the last correctable word of the same type. The first correctable word is not a change. An uncorrectable word is neither compared nor remembered.
- R10: Writing STATUS clears each bit written as 1. If a bit is cleared and set in the same cycle, the set wins. ENABLE and THRESH read back what was last written to them.
- R11: `irq` is high exactly when some STATUS bit and the matching ENABLE bit are both 1.
- R12: A pop request while the FIFO is empty has no effect: the count stays 0 and the next stored block reads back correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| blkValid | input | 1 | A decoded block is present this cycle |
| blkWord | input | 16 | Information word of the block |
| blkPos | input | 2 | Position in the group, 0=A to 3=D |
| blkErr | input | 2 | Error-quality category |
| syncIn | input | 1 | Decoder sync status |
| hostAddr | input | 3 | Register address |
| hostWrEn | input | 1 | Register write strobe |
| hostWrData | input | 16 | Register write data |
| hostRdEn | input | 1 | Read strobe; pops when addressing DATA |
| hostRdData | output | 16 | Register read data for `hostAddr` |
| irq | output | 1 | Interrupt line |

## Verification
The hardest states to reach are the edges of the FIFO and of the status register. One is the full buffer, where a 101st block must be dropped while the 100 stored blocks stay intact. The other is a clear-by-write landing in the same cycle as the event it clears. The bench reaches the full state by streaming exactly 100 directed blocks and then one more, and drains all of them afterwards. For the status edge it drives a STATUS write and a block A arrival at the same clock edge. Seeded random block and pop traffic then runs the change detector against its own remembered A and B words, with uncorrectable blocks mixed in.

// File: rtl/rds_buf_pkg.sv
package rds_buf_pkg;

  localparam int unsigned HOST_W  = 16;
  localparam int unsigned NUM_EVT = 7;

  // block position codes
  localparam logic [1:0] POS_A = 2'd0;
  localparam logic [1:0] POS_B = 2'd1;
  localparam logic [1:0] POS_D = 2'd3;

  // error category codes
  localparam logic [1:0] ERR_UNCORR = 2'b11;

  // status bit positions
  localparam int unsigned EV_SYNC  = 0;
  localparam int unsigned EV_GROUP = 1;
  localparam int unsigned EV_FILL  = 2;
  localparam int unsigned EV_RXA   = 3;
  localparam int unsigned EV_RXB   = 4;
  localparam int unsigned EV_CHGA  = 5;
  localparam int unsigned EV_CHGB  = 6;

  // register addresses
  localparam logic [2:0] ADDR_STATUS = 3'd0;
  localparam logic [2:0] ADDR_ENABLE = 3'd1;
  localparam logic [2:0] ADDR_THRESH = 3'd2;
  localparam logic [2:0] ADDR_LEVEL  = 3'd3;
  localparam logic [2:0] ADDR_DATA   = 3'd4;
  localparam logic [2:0] ADDR_TAG    = 3'd5;

  typedef struct packed {
    logic push;
    logic pop;
    logic trackA;
    logic trackB;
  } fifoStrobe_t;

endpackage

// File: rtl/rds_buf_datapath.sv
module rds_buf_datapath
  import rds_buf_pkg::*;
#(
  parameter int unsigned WORD_W         = 16,
  parameter int unsigned GROUPS         = 25,
  parameter int unsigned BLKS_PER_GROUP = 4,
  localparam int unsigned DEPTH         = GROUPS * BLKS_PER_GROUP,
  localparam int unsigned CNT_W         = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W         = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [WORD_W-1:0] inWord,
  input  logic [1:0]        inPos,
  input  logic [1:0]        inErr,
  output logic [CNT_W-1:0]  level,
  output logic              full,
  output logic              empty,
  output logic [WORD_W-1:0] headWord,
  output logic [1:0]        headPos,
  output logic [1:0]        headErr,
  output logic [1:0]        diff
);

  localparam int unsigned ENT_W = WORD_W + 4;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= {inErr, inPos, inWord};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (strobe.push) wrPtr <= bump(wrPtr);
      if (strobe.pop)  rdPtr <= bump(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: ;
      endcase
    end
  end

  assign full  = (level == FULL_CNT);
  assign empty = (level == '0);
  assign {headErr, headPos, headWord} = mem[rdPtr];

  // last correctable word per tracked block type: index 0 = A, 1 = B
  logic [1:0] trackEn;
  assign trackEn = {strobe.trackB, strobe.trackA};

  for (genvar t = 0; t < 2; t++) begin : gTrack
    logic [WORD_W-1:0] lastWord;
    logic              seen;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lastWord <= '0;
        seen     <= 1'b0;
      end else if (trackEn[t]) begin
        lastWord <= inWord;
        seen     <= 1'b1;
      end
    end
    assign diff[t] = seen && (lastWord != inWord);
  end

  // storage never exceeds its depth
  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    level <= FULL_CNT);

  // no write into a full buffer
  p_no_push_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> !full);

  // no pop from an empty buffer
  p_no_pop_empty_r12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> !empty);

  // a lone push raises the count by one
  p_level_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !strobe.pop) |=> level == $past(level) + 1'b1);

endmodule

// File: rtl/rds_buf_ctrl.sv
module rds_buf_ctrl
  import rds_buf_pkg::*;
#(
  parameter int unsigned BLKS_PER_GROUP = 4,
  parameter int unsigned CNT_W          = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              blkValid,
  input  logic [1:0]        blkPos,
  input  logic [1:0]        blkErr,
  input  logic              syncIn,
  input  logic [2:0]        hostAddr,
  input  logic              hostWrEn,
  input  logic [HOST_W-1:0] hostWrData,
  input  logic              hostRdEn,
  input  logic [CNT_W-1:0]  level,
  input  logic              full,
  input  logic              empty,
  input  logic [HOST_W-1:0] headWord,
  input  logic [1:0]        headPos,
  input  logic [1:0]        headErr,
  input  logic [1:0]        diff,
  output fifoStrobe_t       strobe,
  output logic [HOST_W-1:0] hostRdData,
  output logic              irq
);

  localparam logic [NUM_EVT-1:0] EN_RESET  = NUM_EVT'(3);
  localparam logic [CNT_W-1:0]   THR_RESET = CNT_W'(BLKS_PER_GROUP);

  logic [NUM_EVT-1:0] status;
  logic [NUM_EVT-1:0] enable;
  logic [CNT_W-1:0]   thresh;
  logic               ovf;
  logic               syncQ;

  logic               correctable;
  logic [CNT_W:0]     newLevel;
  logic [NUM_EVT-1:0] evt;
  logic [NUM_EVT-1:0] clr;
  logic               wrStatus;
  logic               wrLevel;
  logic               unusedBits;

  assign correctable   = (blkErr != ERR_UNCORR);
  assign strobe.push   = blkValid && !full;
  assign strobe.pop    = hostRdEn && (hostAddr == ADDR_DATA) && !empty;
  assign strobe.trackA = blkValid && (blkPos == POS_A) && correctable;
  assign strobe.trackB = blkValid && (blkPos == POS_B) && correctable;

  assign newLevel = {1'b0, level} + (CNT_W+1)'(strobe.push) - (CNT_W+1)'(strobe.pop);

  always_comb begin
    evt           = '0;
    evt[EV_SYNC]  = syncIn && !syncQ;
    evt[EV_GROUP] = strobe.push && (blkPos == POS_D);
    evt[EV_FILL]  = strobe.push && (newLevel >= {1'b0, thresh});
    evt[EV_RXA]   = blkValid && (blkPos == POS_A);
    evt[EV_RXB]   = blkValid && (blkPos == POS_B);
    evt[EV_CHGA]  = strobe.trackA && diff[0];
    evt[EV_CHGB]  = strobe.trackB && diff[1];
  end

  assign wrStatus   = hostWrEn && (hostAddr == ADDR_STATUS);
  assign wrLevel    = hostWrEn && (hostAddr == ADDR_LEVEL);
  assign clr        = wrStatus ? hostWrData[NUM_EVT-1:0] : '0;
  assign unusedBits = ^hostWrData[HOST_W-1:CNT_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status <= '0;
      enable <= EN_RESET;
      thresh <= THR_RESET;
      ovf    <= 1'b0;
      syncQ  <= 1'b0;
    end else begin
      status <= (status & ~clr) | evt;
      ovf    <= (blkValid && full) || (ovf && !wrLevel);
      syncQ  <= syncIn;
      if (hostWrEn && hostAddr == ADDR_ENABLE) enable <= hostWrData[NUM_EVT-1:0];
      if (hostWrEn && hostAddr == ADDR_THRESH) thresh <= hostWrData[CNT_W-1:0];
    end
  end

  assign irq = |(status & enable);

  always_comb begin
    hostRdData = '0;
    case (hostAddr)
      ADDR_STATUS: hostRdData[NUM_EVT-1:0] = status;
      ADDR_ENABLE: hostRdData[NUM_EVT-1:0] = enable;
      ADDR_THRESH: hostRdData[CNT_W-1:0]   = thresh;
      ADDR_LEVEL: begin
        hostRdData[CNT_W-1:0] = level;
        hostRdData[14]        = ovf;
        hostRdData[15]        = syncQ;
      end
      ADDR_DATA:   hostRdData = empty ? '0 : headWord;
      ADDR_TAG:    hostRdData[4:0] = {empty, headErr, headPos};
      default:     hostRdData = '0;
    endcase
  end

  logic [NUM_EVT-1:0] keepBits;
  assign keepBits = status & ~clr;

  // status bits not cleared stay set
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((status & $past(keepBits)) == $past(keepBits)));

  // a drop at full sets the overflow flag
  p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (blkValid && full) |=> ovf);

  // rising sync raises its status bit
  p_sync_gain_r5: assert property (@(posedge clk) disable iff (!rstN)
    (syncIn && !syncQ) |=> status[EV_SYNC]);

  // a stored D block raises the group bit
  p_group_r6: assert property (@(posedge clk) disable iff (!rstN)
    (blkValid && !full && blkPos == POS_D) |=> status[EV_GROUP]);

  // no line without an enabled pending source
  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (enable == '0) |-> !irq);

endmodule

// File: rtl/rds_group_buffer.sv
module rds_group_buffer
  import rds_buf_pkg::*;
#(
  parameter int unsigned GROUPS         = 25,
  parameter int unsigned BLKS_PER_GROUP = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        blkValid,
  input  logic [15:0] blkWord,
  input  logic [1:0]  blkPos,
  input  logic [1:0]  blkErr,
  input  logic        syncIn,
  input  logic [2:0]  hostAddr,
  input  logic        hostWrEn,
  input  logic [15:0] hostWrData,
  input  logic        hostRdEn,
  output logic [15:0] hostRdData,
  output logic        irq
);

  localparam int unsigned DEPTH = GROUPS * BLKS_PER_GROUP;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  fifoStrobe_t       strobe;
  logic [CNT_W-1:0]  level;
  logic              full;
  logic              empty;
  logic [HOST_W-1:0] headWord;
  logic [1:0]        headPos;
  logic [1:0]        headErr;
  logic [1:0]        diff;

  rds_buf_datapath #(
    .WORD_W(HOST_W), .GROUPS(GROUPS), .BLKS_PER_GROUP(BLKS_PER_GROUP)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inWord(blkWord), .inPos(blkPos), .inErr(blkErr),
    .level(level), .full(full), .empty(empty),
    .headWord(headWord), .headPos(headPos), .headErr(headErr), .diff(diff)
  );

  rds_buf_ctrl #(
    .BLKS_PER_GROUP(BLKS_PER_GROUP), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .blkValid(blkValid), .blkPos(blkPos), .blkErr(blkErr),
    .syncIn(syncIn), .hostAddr(hostAddr), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdEn(hostRdEn), .level(level), .full(full), .empty(empty),
    .headWord(headWord), .headPos(headPos), .headErr(headErr), .diff(diff),
    .strobe(strobe), .hostRdData(hostRdData), .irq(irq)
  );

endmodule

// File: tb/rds_group_buffer_tb.sv
module rds_group_buffer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        blkValid = 1'b0;
  logic [15:0] blkWord = '0;
  logic [1:0]  blkPos = '0;
  logic [1:0]  blkErr = '0;
  logic        syncIn = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic        hostWrEn = 1'b0;
  logic [15:0] hostWrData = '0;
  logic        hostRdEn = 1'b0;
  logic [15:0] hostRdData;
  logic        irq;

  int testCnt = 0;
  int failCnt = 0;

  // bench model
  logic [19:0] mq [$];
  logic [6:0]  mSts = '0;
  logic [6:0]  mEn = 7'h03;
  int          mThr = 4;
  logic        mOvf = 1'b0;
  logic        mSync = 1'b0;
  logic [15:0] lastA = '0, lastB = '0;
  logic        seenA = 1'b0, seenB = 1'b0;

  always #4 clk = ~clk;

  rds_group_buffer u_dut (
    .clk(clk), .rstN(rstN), .blkValid(blkValid), .blkWord(blkWord), .blkPos(blkPos),
    .blkErr(blkErr), .syncIn(syncIn), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdEn(hostRdEn), .hostRdData(hostRdData), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    hostAddr = a;
    #1 d = hostRdData;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
    case (a)
      3'd0: mSts = mSts & ~d[6:0];
      3'd1: mEn = d[6:0];
      3'd2: mThr = int'(d[6:0]);
      3'd3: mOvf = 1'b0;
      default: ;
    endcase
  endtask

  function automatic void modelBlock(input logic [1:0] p, input logic [15:0] w, input logic [1:0] e);
    if (p == 2'd0) begin
      mSts[3] = 1'b1;
      if (e != 2'b11) begin
        if (seenA && w != lastA) mSts[5] = 1'b1;
        lastA = w; seenA = 1'b1;
      end
    end
    if (p == 2'd1) begin
      mSts[4] = 1'b1;
      if (e != 2'b11) begin
        if (seenB && w != lastB) mSts[6] = 1'b1;
        lastB = w; seenB = 1'b1;
      end
    end
    if (mq.size() < 100) begin
      mq.push_back({e, p, w});
      if (p == 2'd3) mSts[1] = 1'b1;
      if (mq.size() >= mThr) mSts[2] = 1'b1;
    end else begin
      mOvf = 1'b1;
    end
  endfunction

  task automatic send(input logic [1:0] p, input logic [15:0] w, input logic [1:0] e);
    @(negedge clk);
    blkValid = 1'b1; blkPos = p; blkWord = w; blkErr = e;
    @(negedge clk);
    blkValid = 1'b0;
    modelBlock(p, w, e);
  endtask

  task automatic setSync(input logic v);
    @(negedge clk);
    syncIn = v;
    @(negedge clk);
    if (v && !mSync) mSts[0] = 1'b1;
    mSync = v;
  endtask

  task automatic checkState(input string req);
    logic [15:0] d;
    rd(3'd0, d);
    chk(d[6:0] == mSts, {req, " status"}, d[6:0], mSts);
    rd(3'd3, d);
    chk(int'(d[6:0]) == mq.size(), {req, " level"}, d[6:0], mq.size());
    chk(d[14] == mOvf, {req, " overflow"}, d[14], mOvf);
    chk(irq == |(mSts & mEn), {req, " irq (R11)"}, irq, |(mSts & mEn));
  endtask

  task automatic popCheck(input string req);
    logic [15:0] t, w;
    logic [19:0] exp;
    if (mq.size() == 0) return;
    exp = mq.pop_front();
    @(negedge clk);
    hostAddr = 3'd5;
    #1 t = hostRdData;
    hostAddr = 3'd4;
    #1 w = hostRdData;
    hostRdEn = 1'b1;
    @(negedge clk);
    hostRdEn = 1'b0;
    chk(w == exp[15:0], {req, " word"}, w, exp[15:0]);
    chk(t == {11'b0, 1'b0, exp[19:16]}, {req, " tag"}, t, {11'b0, 1'b0, exp[19:16]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    rd(3'd0, d); chk(d == 16'h0, "R1 status", d, 0);
    rd(3'd1, d); chk(d == 16'h3, "R1 enable", d, 3);
    rd(3'd2, d); chk(d == 16'h4, "R1 thresh", d, 4);
    rd(3'd3, d); chk(d == 16'h0, "R1 level", d, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);

    // R5 sync gain, R4 sync bit, R10 clear
    setSync(1'b1);
    checkState("R5");
    rd(3'd3, d); chk(d[15] == 1'b1, "R4 sync bit", d[15], 1);
    wr(3'd0, 16'h0001);
    checkState("R10 clear");

    // R2/R6/R7/R8 directed group
    send(2'd0, 16'h1111, 2'b00);
    send(2'd1, 16'h2222, 2'b01);
    send(2'd2, 16'h3333, 2'b10);
    send(2'd3, 16'h4444, 2'b11);
    checkState("R6 R7 R8 group");
    for (int i = 0; i < 4; i++) popCheck("R2 order");
    wr(3'd0, 16'h007f);
    checkState("R10 clear all");

    // R9 change detection
    send(2'd0, 16'h1111, 2'b00);
    checkState("R9 same A");
    send(2'd0, 16'hbeef, 2'b11);
    checkState("R9 uncorrectable A ignored");
    send(2'd0, 16'h1111, 2'b10);
    checkState("R9 A after uncorrectable");
    send(2'd0, 16'h5555, 2'b01);
    checkState("R9 A changed");
    send(2'd1, 16'h2223, 2'b00);
    checkState("R9 B changed");
    wr(3'd1, 16'h0040);
    rd(3'd1, d); chk(d == 16'h0040, "R10 enable readback", d, 16'h40);
    checkState("R11 B change only");
    wr(3'd0, 16'h0040);
    checkState("R11 masked");
    while (mq.size() > 0) popCheck("R2 drain");
    wr(3'd0, 16'h007f);
    wr(3'd1, 16'h007f);

    // R7 threshold of one and of ten
    wr(3'd2, 16'd1);
    send(2'd2, 16'h0001, 2'b00);
    checkState("R7 thr1");
    popCheck("R7 thr1 pop");
    wr(3'd0, 16'h007f);
    wr(3'd2, 16'd10);
    for (int i = 0; i < 9; i++) send(2'd2, 16'(i), 2'b00);
    checkState("R7 below thr10");
    send(2'd2, 16'h00aa, 2'b00);
    checkState("R7 at thr10");
    while (mq.size() > 0) popCheck("R7 drain");
    wr(3'd0, 16'h007f);

    // R3 capacity and overflow
    for (int i = 0; i < 100; i++) send(2'(i % 4), 16'(16'h8000 + i), 2'(i % 3));
    checkState("R3 full");
    send(2'd2, 16'hdead, 2'b00);
    checkState("R3 overflow");
    wr(3'd3, 16'h0000);
    checkState("R3 overflow clear");
    while (mq.size() > 0) popCheck("R3 contents");
    wr(3'd0, 16'h007f);

    // R12 pop when empty
    @(negedge clk);
    hostAddr = 3'd4; hostRdEn = 1'b1;
    @(negedge clk);
    hostRdEn = 1'b0;
    rd(3'd5, d); chk(d[4] == 1'b1, "R12 empty tag", d[4], 1);
    checkState("R12 empty pop");
    send(2'd2, 16'h0c0c, 2'b01);
    popCheck("R12 after empty pop");
    wr(3'd0, 16'h007f);

    // R10 set wins over clear in the same cycle
    @(negedge clk);
    blkValid = 1'b1; blkPos = 2'd0; blkWord = 16'h5555; blkErr = 2'b00;
    hostWrEn = 1'b1; hostAddr = 3'd0; hostWrData = 16'h0008;
    @(negedge clk);
    blkValid = 1'b0; hostWrEn = 1'b0;
    modelBlock(2'd0, 16'h5555, 2'b00);
    checkState("R10 set wins");
    wr(3'd0, 16'h007f);

    // random traffic
    wr(3'd2, 16'd6);
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 11);
      if (op < 6)
        send(2'($urandom_range(0, 3)), 16'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
      else if (op < 9)
        popCheck("R2 R9 random pop");
      else if (op == 9)
        wr(3'd0, 16'($urandom_range(0, 127)));
      else if (op == 10)
        wr(3'd1, 16'($urandom_range(0, 127)));
      else
        setSync(~mSync);
      checkState("R5 R8 R9 random");
    end

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule